// File: doc/BRIEF.md
# Two-Bit Sequence Lock Controller

A clocked Moore state machine that watches a two-bit key pair and opens only when four consecutive clock samples form the code 00, 01, 01, 10. Every rising clock edge takes one sample, so a held input counts once per clock period. The two 01 samples therefore have to span two separate clock periods. A sample that does not fit the code sends the machine back to the start. The exception is a 00 sample: it always counts as the first step of a fresh attempt.

The state is held in three flip-flops with a fixed binary assignment: idle 000, first step 001, second step 011, third step 010 and open 100. The unlock output is the top state bit, taken straight from its flip-flop, so it never glitches. The three unused codes drop back to idle on the next clock whatever the input. The key inputs must already be synchronous to the clock.

Top module: `seqlock_ctrl`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the machine returns to idle, and `unlock` is low in the cycle after that edge. After reset, an attempt must begin again with 00.
- R2: Feed the samples 00, 01, 01, 10 on four consecutive rising edges. `unlock` then goes high after the edge that samples 10 and stays high for exactly one clock period.
- R3: Sampling 00 (`key_pair` = 2'b00) in any state moves the machine to the first step. A sequence that restarts with 00 part-way through still opens once the rest of the code follows.
- R4: During an attempt, a sample other than the expected symbol (and other than 00) returns the machine to idle. For example, 00, 01, 10 does not open.
- R5: The symbol 11 never belongs to the code and always returns the machine to idle.
- R6: In the open state, a 00 sample begins a new attempt, so two codes fed back to back open twice.
- R7: A third 01 in a row breaks the attempt. The input 00, 01, 01, 01, 10 does not open.
- R8: In the open state, a sample of 01, 10 or 11 returns the machine to idle. The steps that follow must then start with 00 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the key pair is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset to idle |
| key_pair | input | 2 | Key inputs, bit 1 is the first key and bit 0 the second |
| unlock | output | 1 | High for one period while the machine is in the open state |

## Verification
The only port that shows the state is `unlock`. A wrong step or a wrong return to idle therefore shows up only as a missing or extra open pulse. That pulse appears on the edge that takes the final 10 sample, so it can lag the faulty transition by up to three samples. Each scenario ends with the 10 sample, so a fault in any earlier step shows at the last sample of that scenario. The code ends with 10, so a machine stuck anywhere other than the third step stays closed. A machine that holds the open state too long shows up one period after the pulse.

// File: rtl/seqlock_pkg.sv
package seqlock_pkg;
  localparam int KEY_W = 2;
  localparam int ST_W  = 3;

  typedef enum logic [ST_W-1:0] {
    LK_IDLE = 3'b000,
    LK_GOT1 = 3'b001,
    LK_GOT2 = 3'b011,
    LK_GOT3 = 3'b010,
    LK_OPEN = 3'b100
  } lk_state_t;

  localparam logic [KEY_W-1:0] SYM_START = 2'b00;
  localparam logic [KEY_W-1:0] SYM_MID   = 2'b01;
  localparam logic [KEY_W-1:0] SYM_LAST  = 2'b10;

  // True for the five assigned state codes.
  function automatic logic is_legal(input logic [ST_W-1:0] s);
    case (s)
      LK_IDLE, LK_GOT1, LK_GOT2, LK_GOT3, LK_OPEN: return 1'b1;
      default:                                     return 1'b0;
    endcase
  endfunction

  // Symbol the machine expects while in state s (only meaningful mid-attempt).
  function automatic logic step_match(input logic [ST_W-1:0] s,
                                      input logic [KEY_W-1:0] k);
    return ((s == LK_GOT1) && (k == SYM_MID)) ||
           ((s == LK_GOT2) && (k == SYM_MID)) ||
           ((s == LK_GOT3) && (k == SYM_LAST));
  endfunction

  // Successor state on a correct step.
  function automatic lk_state_t advance(input logic [ST_W-1:0] s);
    case (s)
      LK_GOT1: return LK_GOT2;
      LK_GOT2: return LK_GOT3;
      LK_GOT3: return LK_OPEN;
      default: return LK_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/seqlock_decode.sv
module seqlock_decode
  import seqlock_pkg::*;
(
  input  logic [ST_W-1:0]  cur_st,
  input  logic [KEY_W-1:0] key_pair,
  output logic             start_hit,
  output logic             step_ok,
  output logic             legal
);
  always_comb begin
    legal     = is_legal(cur_st);
    start_hit = (key_pair == SYM_START);
    step_ok   = step_match(cur_st, key_pair);
  end
endmodule

// File: rtl/seqlock_state_reg.sv
module seqlock_state_reg
  import seqlock_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] d,
  output logic [ST_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= LK_IDLE;
    else     q <= d;
  end
endmodule

// File: rtl/seqlock_ctrl.sv
module seqlock_ctrl
  import seqlock_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [KEY_W-1:0] key_pair,
  output logic             unlock
);
  logic [ST_W-1:0] state_q;
  logic [ST_W-1:0] state_d;
  logic            start_hit;
  logic            step_ok;
  logic            legal;

  seqlock_decode u_decode (
    .cur_st    (state_q),
    .key_pair  (key_pair),
    .start_hit (start_hit),
    .step_ok   (step_ok),
    .legal     (legal)
  );

  always_comb begin
    if (!legal)         state_d = LK_IDLE;
    else if (start_hit) state_d = LK_GOT1;
    else if (step_ok)   state_d = advance(state_q);
    else                state_d = LK_IDLE;
  end

  seqlock_state_reg u_state (
    .clk (clk),
    .rst (rst),
    .d   (state_d),
    .q   (state_q)
  );

  assign unlock = state_q[ST_W-1];
endmodule

// File: rtl/seqlock_ctrl_chk.sv
module seqlock_ctrl_chk
  import seqlock_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [KEY_W-1:0] key_pair,
  input logic             unlock,
  input logic [ST_W-1:0]  state_q,
  input logic             start_hit,
  input logic             step_ok,
  input logic             legal
);
  AST_RESET_CLOSES: assert property (@(posedge clk) rst |=> !unlock); // R1
  AST_OPEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    unlock |=> !unlock); // R2
  AST_OPEN_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock) |-> ($past(key_pair) == SYM_LAST && $past(state_q) == LK_GOT3)); // R2
  AST_ZERO_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (legal && start_hit) |=> (state_q == LK_GOT1)); // R3
  AST_WRONG_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!start_hit && !step_ok) |=> (state_q == LK_IDLE)); // R4
  AST_ELEVEN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (key_pair == 2'b11) |=> (state_q == LK_IDLE && !unlock)); // R5
  AST_OPEN_EXIT: assert property (@(posedge clk) disable iff (rst)
    (unlock && key_pair != SYM_START) |=> (state_q == LK_IDLE)); // R8
endmodule

bind seqlock_ctrl seqlock_ctrl_chk u_seqlock_ctrl_chk (
  .clk       (clk),
  .rst       (rst),
  .key_pair  (key_pair),
  .unlock    (unlock),
  .state_q   (state_q),
  .start_hit (start_hit),
  .step_ok   (step_ok),
  .legal     (legal)
);

// File: tb/seqlock_ctrl_bench.sv
module seqlock_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] key_pair = 2'b11;
  logic       unlock;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  seqlock_ctrl u_seqlock_ctrl (
    .clk      (clk),
    .rst      (rst),
    .key_pair (key_pair),
    .unlock   (unlock)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (unlock !== exp) begin
      failures++;
      $display("FAIL %s: unlock=%b expected=%b at %0t", req, unlock, exp, $time);
    end
  endtask

  // Drive one sample, let the edge take it, check the registered output.
  task automatic put(input logic [1:0] sym, input logic exp, input string req);
    @(negedge clk) key_pair = sym;
    @(posedge clk);
    #1 check(req, exp);
  endtask

  task automatic clear();
    put(2'b11, 1'b0, "R5");
  endtask

  task automatic t_reset();
    @(negedge clk) rst = 1'b1;
    key_pair = 2'b00;
    @(posedge clk); #1 check("R1", 1'b0);
    @(negedge clk) rst = 1'b0;
    put(2'b00, 0, "R1"); put(2'b01, 0, "R1"); put(2'b01, 0, "R1");
    @(negedge clk) rst = 1'b1; key_pair = 2'b10;
    @(posedge clk); #1 check("R1", 1'b0);
    @(negedge clk) rst = 1'b0;
    put(2'b10, 0, "R1");
  endtask

  task automatic t_basic();
    put(2'b00, 0, "R2"); put(2'b01, 0, "R2"); put(2'b01, 0, "R2");
    put(2'b10, 1, "R2");
    put(2'b11, 0, "R2");
  endtask

  task automatic t_single_mid();
    put(2'b00, 0, "R4"); put(2'b01, 0, "R4"); put(2'b10, 0, "R4");
    put(2'b01, 0, "R4"); put(2'b01, 0, "R4"); put(2'b10, 0, "R4");
  endtask

  task automatic t_triple_mid();
    put(2'b00, 0, "R7"); put(2'b01, 0, "R7"); put(2'b01, 0, "R7");
    put(2'b01, 0, "R7"); put(2'b10, 0, "R7");
  endtask

  task automatic t_restart();
    put(2'b00, 0, "R3"); put(2'b01, 0, "R3"); put(2'b00, 0, "R3");
    put(2'b01, 0, "R3"); put(2'b01, 0, "R3"); put(2'b10, 1, "R3");
    clear();
    put(2'b00, 0, "R3"); put(2'b00, 0, "R3"); put(2'b00, 0, "R3");
    put(2'b01, 0, "R3"); put(2'b01, 0, "R3"); put(2'b10, 1, "R3");
    clear();
  endtask

  task automatic t_eleven();
    put(2'b00, 0, "R5"); put(2'b01, 0, "R5"); put(2'b11, 0, "R5");
    put(2'b01, 0, "R5"); put(2'b10, 0, "R5");
    put(2'b00, 0, "R5"); put(2'b01, 0, "R5"); put(2'b01, 0, "R5");
    put(2'b11, 0, "R5"); put(2'b10, 0, "R5");
  endtask

  task automatic t_back_to_back();
    put(2'b00, 0, "R6"); put(2'b01, 0, "R6"); put(2'b01, 0, "R6");
    put(2'b10, 1, "R6");
    put(2'b00, 0, "R6"); put(2'b01, 0, "R6"); put(2'b01, 0, "R6");
    put(2'b10, 1, "R6");
    clear();
  endtask

  task automatic t_open_exit();
    put(2'b00, 0, "R8"); put(2'b01, 0, "R8"); put(2'b01, 0, "R8");
    put(2'b10, 1, "R8");
    put(2'b01, 0, "R8"); put(2'b01, 0, "R8"); put(2'b10, 0, "R8");
    put(2'b00, 0, "R8"); put(2'b01, 0, "R8"); put(2'b01, 0, "R8");
    put(2'b10, 1, "R8");
    put(2'b10, 0, "R8"); put(2'b01, 0, "R8"); put(2'b01, 0, "R8");
    put(2'b10, 0, "R8");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", 1'b0);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_basic();
    t_single_mid();
    t_triple_mid();
    t_restart();
    t_eleven();
    t_back_to_back();
    t_open_exit();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule